// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous control path of a pipelined burst static RAM built around a small array of 32-bit words. On every rising clock edge it samples three chip enables, two address strobes, a burst-advance input, the write controls and a snooze input. From these it decides whether the cycle starts a new burst, continues or holds the current one, deselects the device, or does nothing. One strobe belongs to a processor. The other belongs to a cache controller.

Writes can be one to four bytes wide, selected per lane, and complete inside the block. Reads are pipelined. The address is registered on one edge, and the word comes out of an output register after the following edge. An asynchronous output enable gates the output. The tri-state pads are not modelled. A drive flag marks the cycles in which data would be on the pins.

A burst covers four words inside an aligned group of four. The burst order is either linear (wrapping increment) or interleaved (XOR), chosen by a mode input. A snooze request stops all activity after a two-cycle delay. The array keeps its contents while the block is in snooze.

Top module: `pbsram_ctrl`

## Requirements
- R1: After reset `rd_drive` is 0 and no burst is open. An advance (`step_n`=0) given with no strobe produces no output.
- R2: A read addressed on edge k is not driven after edge k when the preceding cycle was not a read. After edge k+1 it shows `rd_drive`=1 and the stored word.
- R3: Lane write decode. `wr_all_n`=0 writes all four lanes. Otherwise `lane_wr_en_n`=0 writes each lane i whose `lane_sel_n[i]`=0, where lane i is bits 8i+7:8i (bit 0 → 7:0, bit 3 → 31:24). A controller-started cycle that selects no lane is a read.
- R4: A burst started by `cpu_strb_n`=0 with all enables active is always a read, whatever the write inputs are, and it leaves the array unchanged.
- R5: The chip enables count as active when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. With `ctl_strb_n`=0 and any enable inactive, the cycle deselects and writes nothing. With `cpu_strb_n`=0 and `en_a_n`=1, that strobe is ignored. With `cpu_strb_n`=0, `en_a_n`=0 and `en_b` or `en_c_n` inactive, the cycle deselects.
- R6: In cycles with no effective strobe, the chip enables are ignored and an open burst continues.
- R7: The burst address keeps the upper address bits. The low two bits are (start + n) mod 4 when `order_sel`=0, and start XOR n when `order_sel`=1, for beats n = 0..3.
- R8: With a burst open and `step_n`=1, the cycle repeats the current address.
- R9: A deselect cycle closes the open burst. Later advances without a new strobe produce no output.
- R10: `rd_drive` is 1 only while `out_en_n`=0, and it follows `out_en_n` without a clock edge. `rd_data` reads 0 whenever `rd_drive` is 0.
- R11: A write cycle is never driven. A word written on edge k is returned by a read addressed on edge k+1.
- R12: Continue and hold cycles keep the direction of the burst's first cycle. Write beats use the write data and lane selects present in their own cycle, and a write beat with no lane selected changes nothing.
- R13: A strobe on edge e is acted on only if `doze` was 0 on edge e-2. While a strobe is being ignored for that reason, any open burst is closed, and the output is undriven in the cycle that follows. Array contents survive the snooze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wr_data | input | DATA_W | Write data |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Snooze request |
| rd_data | output | DATA_W | Read data, zero when undriven |
| rd_drive | output | 1 | Output would be driven |

## Verification
The assertions assume that `doze` and the strobes are known, synchronous levels from the end of reset onward. They also assume that `out_en_n` changes only between clock edges, so its sampled value matches the gate the output saw. The stimulus changes every input on falling edges and holds `doze` low through reset. It toggles `out_en_n` only in the middle of a low clock phase. Snooze entry and exit are checked against their own two-edge delay, which the checker keeps independently of the design.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    localparam int BEAT_W    = 2;
    localparam int BURST_LEN = 1 << BEAT_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_DESEL = 3'd1,
        ACT_START = 3'd2,
        ACT_CONT  = 3'd3,
        ACT_HOLD  = 3'd4
    } act_e;

    // low address bits of beat n for a burst that began at offset lo
    function automatic logic [BEAT_W-1:0] beat_ofs(
        input logic [BEAT_W-1:0] lo,
        input logic [BEAT_W-1:0] n,
        input logic              ilv
    );
        return ilv ? (lo ^ n) : (lo + n);
    endfunction

endpackage

// File: rtl/pbsram_lane_dec.sv
module pbsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !wr_all_n || (!lane_wr_en_n && !lane_sel_n[g]);
    end

endmodule

// File: rtl/pbsram_burst_seq.sv
module pbsram_burst_seq
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [BEAT_W-1:0] beat;

    always_comb begin
        s_d  = s_q;
        beat = adv_i ? s_q.cnt + 1'b1 : s_q.cnt;
        if (start_i) begin
            s_d.base = addr_i;
            s_d.cnt  = '0;
            addr_o   = addr_i;
        end else begin
            s_d.cnt = beat;
            addr_o  = {s_q.base[ADDR_W-1 -: HI_W],
                       beat_ofs(s_q.base[BEAT_W-1:0], beat, order_i)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wd,
    output logic [LANES*LANE_W-1:0] rd
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[addr] <= wd[g*LANE_W +: LANE_W];
        end

        assign rd[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              order_sel,
    input  logic              out_en_n,
    input  logic              doze,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    localparam int LANE_W = DATA_W / LANES;
    localparam int ZZ_LAT = 2;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wd;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        logic              rd;
        logic [DATA_W-1:0] dout;
        logic              burst;
        op_e               dir;
        logic [ZZ_LAT-1:0] zz;
    } regs_t;

    regs_t r_d, r_q;

    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] arr_rd;
    logic [LANES-1:0]  arr_we;
    logic              blk;
    logic              ens_ok;
    logic              start_wr;
    act_e              act;

    pbsram_lane_dec #(.LANES(LANES)) u_dec (
        .wr_all_n    (wr_all_n),
        .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n  (lane_sel_n),
        .lane_we     (lane_we)
    );

    // cycle decision from the strobes, enables and the snooze gate
    always_comb begin
        blk      = r_q.zz[ZZ_LAT-1];
        ens_ok   = en_b && !en_c_n;
        act      = ACT_IDLE;
        start_wr = 1'b0;
        if (blk) begin
            act = ACT_DESEL;
        end else if (!cpu_strb_n && !en_a_n) begin
            act = ens_ok ? ACT_START : ACT_DESEL;
        end else if (!ctl_strb_n) begin
            act      = (ens_ok && !en_a_n) ? ACT_START : ACT_DESEL;
            start_wr = |lane_we;
        end else if (r_q.burst) begin
            act = step_n ? ACT_HOLD : ACT_CONT;
        end
    end

    pbsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(act == ACT_START),
        .adv_i  (act == ACT_CONT),
        .order_i(order_sel),
        .addr_i (addr),
        .addr_o (seq_addr)
    );

    assign arr_we = (r_q.s1.op == OP_WRITE) ? r_q.s1.be : '0;

    pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk (clk),
        .we  (arr_we),
        .addr(r_q.s1.addr),
        .wd  (r_q.s1.wd),
        .rd  (arr_rd)
    );

    always_comb begin
        r_d         = r_q;
        r_d.s1.addr = seq_addr;
        r_d.s1.be   = lane_we;
        r_d.s1.wd   = wr_data;
        unique case (act)
            ACT_START: begin
                r_d.s1.op = start_wr ? OP_WRITE : OP_READ;
                r_d.dir   = start_wr ? OP_WRITE : OP_READ;
                r_d.burst = 1'b1;
            end
            ACT_CONT, ACT_HOLD: r_d.s1.op = r_q.dir;
            ACT_DESEL: begin
                r_d.s1.op = OP_NONE;
                r_d.burst = 1'b0;
            end
            default: r_d.s1.op = OP_NONE;
        endcase
        r_d.rd = (r_q.s1.op == OP_READ);
        if (r_d.rd) r_d.dout = arr_rd;
        r_d.zz = {r_q.zz[ZZ_LAT-2:0], doze};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_drive = r_q.rd && !out_en_n && !blk;
    assign rd_data  = rd_drive ? r_q.dout : '0;

endmodule

// File: rtl/pbsram_ctrl_chk.sv
module pbsram_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             cpu_strb_n,
    input logic             ctl_strb_n,
    input logic             wr_all_n,
    input logic             lane_wr_en_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             out_en_n,
    input logic             doze,
    input logic             rd_drive
);

    logic z1, z2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z1 <= 1'b0;
            z2 <= 1'b0;
        end else begin
            z1 <= doze;
            z2 <= z1;
        end
    end

    logic all_en, cpu_go, wr_go, desel;
    assign all_en = !en_a_n && en_b && !en_c_n;
    assign cpu_go = !z2 && !cpu_strb_n && all_en;
    assign wr_go  = !z2 && cpu_strb_n && !ctl_strb_n && all_en &&
                    (!wr_all_n || (!lane_wr_en_n && lane_sel_n != '1));
    assign desel  = !z2 && !ctl_strb_n && (cpu_strb_n || en_a_n) && !all_en;

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> !out_en_n);

    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ##1 !rd_drive);

    p_desel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> ##1 !rd_drive);

    p_cpu_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_go |=> ##1 (rd_drive || out_en_n || z2));

    p_snooze_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        z2 |-> !rd_drive);

endmodule

bind pbsram_ctrl pbsram_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .cpu_strb_n  (cpu_strb_n),
    .ctl_strb_n  (ctl_strb_n),
    .wr_all_n    (wr_all_n),
    .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n  (lane_sel_n),
    .out_en_n    (out_en_n),
    .doze        (doze),
    .rd_drive    (rd_drive)
);

// File: tb/pbsram_ctrl_tb.sv
module pbsram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        en_a_n, en_b, en_c_n;
    logic        cpu_strb_n, ctl_strb_n, step_n;
    logic        wr_all_n, lane_wr_en_n;
    logic [3:0]  lane_sel_n;
    logic [31:0] wr_data;
    logic        order_sel, out_en_n, doze;
    logic [31:0] rd_data;
    logic        rd_drive;

    logic [31:0] mm [16];
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pbsram_ctrl #(.ADDR_W(4), .LANES(4), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .wr_data(wr_data), .order_sel(order_sel), .out_en_n(out_en_n), .doze(doze),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        addr = '0; en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF; wr_data = '0;
    endtask

    task automatic exp_rd(input string req, input bit ev, input logic [31:0] ed);
        n_chk++;
        if (ev) begin
            if (rd_drive !== 1'b1 || rd_data !== ed) begin
                n_bad++;
                $display("FAIL %s: drive=%b data=%h expected drive=1 data=%h",
                         req, rd_drive, rd_data, ed);
            end
        end else if (rd_drive !== 1'b0 || rd_data !== 32'h0) begin
            n_bad++;
            $display("FAIL %s: drive=%b data=%h expected drive=0 data=00000000",
                     req, rd_drive, rd_data);
        end
    endtask

    function automatic logic [3:0] baddr(input logic [3:0] a, input int b, input logic ilv);
        logic [1:0] n = 2'(b);
        return {a[3:2], ilv ? (a[1:0] ^ n) : (a[1:0] + n)};
    endfunction

    // controller-strobe single cycle; checks drive after the following edge
    task automatic cwr(input logic [3:0] a, input logic [31:0] d, input logic g_n,
                       input logic b_n, input logic [3:0] sel_n, input string req);
        logic [3:0] lanes;
        idle_in(); ctl_strb_n = 1'b0; addr = a; wr_data = d;
        wr_all_n = g_n; lane_wr_en_n = b_n; lane_sel_n = sel_n;
        lanes = !g_n ? 4'hF : (!b_n ? ~sel_n : 4'h0);
        tick(); idle_in(); tick();
        if (lanes == 4'h0) exp_rd(req, 1'b1, mm[a]);
        else begin
            for (int i = 0; i < 4; i++) if (lanes[i]) mm[a][8*i +: 8] = d[8*i +: 8];
            exp_rd(req, 1'b0, '0);
        end
    endtask

    task automatic rd1(input logic [3:0] a, input string req);
        idle_in(); cpu_strb_n = 1'b0; addr = a;
        tick(); idle_in(); tick();
        exp_rd(req, 1'b1, mm[a]);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        idle_in(); rst_n = 1'b0; out_en_n = 1'b0; doze = 1'b0; order_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        exp_rd("R1 reset", 1'b0, '0);
        step_n = 1'b0; tick(); tick();
        exp_rd("R1 advance without burst", 1'b0, '0);

        // R2 / R11: fill every word, then read it back with pipeline timing
        for (int a = 0; a < 16; a++) begin
            mm[a] = 32'h0;
            cwr(4'(a), 32'hA5000000 ^ (32'(a) * 32'h01010101), 1'b0, 1'b1, 4'hF, "R11 write undriven");
            idle_in(); cpu_strb_n = 1'b0; addr = 4'(a);
            tick();
            exp_rd("R2 not yet driven", 1'b0, '0);
            idle_in(); tick();
            exp_rd("R2 read data", 1'b1, mm[a]);
        end

        // R7: every start offset in both orders
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                order_sel = m[0];
                idle_in(); cpu_strb_n = 1'b0; addr = 4'(a);
                tick();
                for (int b = 1; b <= 4; b++) begin
                    idle_in(); step_n = (b < 4) ? 1'b0 : 1'b1;
                    tick();
                    exp_rd("R7 burst beat", 1'b1, mm[baddr(4'(a), b - 1, m[0])]);
                end
            end
        end
        order_sel = 1'b0;

        // R8: hold in the middle of a burst
        idle_in(); cpu_strb_n = 1'b0; addr = 4'h9; tick();
        idle_in(); step_n = 1'b0; tick(); exp_rd("R8 beat0", 1'b1, mm[9]);
        idle_in(); step_n = 1'b1; tick(); exp_rd("R8 beat1", 1'b1, mm[10]);
        idle_in(); step_n = 1'b0; tick(); exp_rd("R8 held", 1'b1, mm[10]);
        idle_in(); tick();                exp_rd("R8 after hold", 1'b1, mm[11]);

        // R5 / R6: blocked processor strobe and ignored enables continue a burst
        idle_in(); cpu_strb_n = 1'b0; addr = 4'hC; tick();
        idle_in(); cpu_strb_n = 1'b0; en_a_n = 1'b1; addr = 4'h3; step_n = 1'b0; tick();
        exp_rd("R5 beat0", 1'b1, mm[12]);
        idle_in(); en_b = 1'b0; en_c_n = 1'b1; step_n = 1'b0; tick();
        exp_rd("R5 blocked strobe continues", 1'b1, mm[13]);
        idle_in(); tick();
        exp_rd("R6 enables ignored", 1'b1, mm[14]);

        // R5: controller strobe with each enable inactive deselects, no write
        for (int v = 0; v < 3; v++) begin
            idle_in(); ctl_strb_n = 1'b0; addr = 4'h2; wr_all_n = 1'b0; wr_data = ~mm[2];
            if (v == 0) en_a_n = 1'b1;
            if (v == 1) en_b = 1'b0;
            if (v == 2) en_c_n = 1'b1;
            tick(); idle_in(); tick();
            exp_rd("R5 controller deselect", 1'b0, '0);
            rd1(4'h2, "R5 no write on deselect");
        end
        idle_in(); cpu_strb_n = 1'b0; addr = 4'h3; en_c_n = 1'b1; tick();
        idle_in(); tick();
        exp_rd("R5 processor deselect", 1'b0, '0);
        idle_in(); cpu_strb_n = 1'b0; en_a_n = 1'b1; addr = 4'h3; tick();
        idle_in(); tick();
        exp_rd("R5 blocked strobe no burst", 1'b0, '0);

        // R9: deselect closes the burst
        idle_in(); cpu_strb_n = 1'b0; addr = 4'h2; tick();
        idle_in(); ctl_strb_n = 1'b0; en_a_n = 1'b1; tick();
        idle_in(); step_n = 1'b0; tick();
        exp_rd("R9 deselect", 1'b0, '0);
        idle_in(); step_n = 1'b0; tick();
        exp_rd("R9 advance after deselect", 1'b0, '0);

        // R3: every lane-select pattern, the all-lanes override, the read case
        for (int m = 0; m < 16; m++) begin
            cwr(4'hA, 32'h11223344, 1'b0, 1'b1, 4'hF, "R3 preset");
            cwr(4'hA, 32'hCAFEF00D, 1'b1, 1'b0, 4'(m), "R3 lane write");
            rd1(4'hA, "R3 lane result");
        end
        cwr(4'hA, 32'h5A5A0F0F, 1'b0, 1'b1, 4'hF, "R3 all-lanes override");
        rd1(4'hA, "R3 override result");
        cwr(4'hA, 32'h00000000, 1'b1, 1'b1, 4'h0, "R3 no enable is read");

        // R4: processor strobe never writes
        idle_in(); cpu_strb_n = 1'b0; addr = 4'h7; wr_all_n = 1'b0; lane_wr_en_n = 1'b0;
        lane_sel_n = 4'h0; wr_data = ~mm[7];
        tick(); idle_in(); tick();
        exp_rd("R4 processor start reads", 1'b1, mm[7]);
        rd1(4'h7, "R4 array unchanged");

        // R10: asynchronous output enable
        rd1(4'h1, "R10 base read");
        #1 out_en_n = 1'b1;
        #1 exp_rd("R10 disabled", 1'b0, '0);
        out_en_n = 1'b0;
        #1 exp_rd("R10 re-enabled", 1'b1, mm[1]);
        @(negedge clk);

        // R12: write burst keeps direction, per-beat data and lanes
        idle_in(); ctl_strb_n = 1'b0; addr = 4'h5; wr_all_n = 1'b0; wr_data = 32'hD0D0D0D0; tick();
        idle_in(); step_n = 1'b0; wr_all_n = 1'b0; wr_data = 32'hD1D1D1D1; tick();
        exp_rd("R12 write beat0", 1'b0, '0);
        idle_in(); step_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 4'h0; wr_data = 32'hD2D2D2D2; tick();
        exp_rd("R12 write beat1", 1'b0, '0);
        idle_in(); step_n = 1'b0; wr_data = 32'hD3D3D3D3; tick();
        exp_rd("R12 write beat2", 1'b0, '0);
        idle_in(); ctl_strb_n = 1'b0; en_b = 1'b0; tick();
        exp_rd("R12 write beat3", 1'b0, '0);
        mm[5] = 32'hD0D0D0D0; mm[6] = 32'hD1D1D1D1; mm[7] = 32'hD2D2D2D2;
        rd1(4'h5, "R12 beat0 stored");
        rd1(4'h6, "R12 beat1 stored");
        rd1(4'h7, "R12 beat2 stored");
        rd1(4'h4, "R12 empty beat unchanged");

        // R13: snooze entry and exit delays
        idle_in(); tick();
        doze = 1'b1;
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h0; wr_data = 32'h0E0E0E0E; tick();
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h1; wr_data = 32'h1E1E1E1E; tick();
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h2; wr_data = 32'h2E2E2E2E; tick();
        idle_in(); cpu_strb_n = 1'b0; addr = 4'h3; tick();
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h3; wr_data = 32'h3E3E3E3E; tick();
        exp_rd("R13 read ignored in snooze", 1'b0, '0);
        doze = 1'b0;
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h4; wr_data = 32'h4E4E4E4E; tick();
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h5; wr_data = 32'h5E5E5E5E; tick();
        idle_in(); ctl_strb_n = 1'b0; wr_all_n = 1'b0; addr = 4'h6; wr_data = 32'h6E6E6E6E; tick();
        mm[0] = 32'h0E0E0E0E; mm[1] = 32'h1E1E1E1E; mm[6] = 32'h6E6E6E6E;
        for (int a = 0; a < 8; a++) rd1(4'(a), "R13 contents after snooze");

        finish_run();
    end

endmodule